// File: doc/BRIEF.md
# Register-to-Register Subtract and Shift Execute Unit

This block carries out the register-to-register subtract and shift operations of a small 8-bit virtual machine. It owns a file of sixteen 8-bit registers, the last of which (index 15) doubles as the flag register, and a 12-bit program counter. An instruction word is presented for one cycle with `instr_valid`. The unit decodes it, reads the two source registers, computes a result and a flag, and writes both back on the same clock edge. It also steps the program counter by 2 and pulses `done` in the following cycle.

The instruction is recognised by a group nibble of 0x8 in bits [15:12]. Bits [11:8] name the destination register x and bits [7:4] name the second operand register y. The operation is taken from bits [3:0]. Any other word is treated as a no-operation: it still consumes a program-counter step and still produces `done`.

A preload port seeds register values, and a debug read port exposes any register. Both exist so that the block can be exercised on its own.

Top module: `regop_exec`

## Requirements
- R1: While reset (`rst_n` low) is held and after it is released, all sixteen registers read 0x00, `pc_out` reads 0x200 and `done` is 0.
- R2: Operation code 0x5 (subtract) writes (Vx - Vy) mod 256 to Vx and sets register 15 to 1 only when Vx is strictly greater than Vy; equal operands give 0.
- R3: Operation code 0x7 (reverse subtract) writes (Vy - Vx) mod 256 to Vx and sets register 15 to 1 only when Vy is strictly greater than Vx.
- R4: Operation code 0x6 (shift right) writes register 15 with bit 0 of the old Vx, and writes Vx shifted right by one with a zero fill into Vx.
- R5: Operation code 0xE (shift left) writes register 15 with bit 7 of the old Vx, and writes the low 8 bits of Vx shifted left by one into Vx.
- R6: When x is 15, register 15 ends up holding the arithmetic result rather than the flag.
- R7: When x equals y, both operands are the value the register held before the instruction.
- R8: A word whose bits [15:12] are not 0x8, or whose bits [3:0] are not 0x5, 0x6, 0x7 or 0xE, changes no register. It still advances the program counter and still pulses `done`.
- R9: Each accepted word adds 2 to `pc_out`, modulo 4096. Words may arrive on consecutive cycles. `done` is high for exactly the one cycle after each cycle with `instr_valid` high.
- R10: Both shifts ignore Vy: the result does not depend on it, and Vy keeps its value unless it is x or 15.
- R11: `pre_valid` writes `pre_data` into register `pre_idx` on the next edge when `instr_valid` is low. When `instr_valid` is high in the same cycle, the preload is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr_word | input | 16 | Instruction word |
| pre_valid | input | 1 | Preload write strobe |
| pre_idx | input | 4 | Preload register index |
| pre_data | input | 8 | Preload value |
| dbg_sel | input | 4 | Debug read register index |
| dbg_data | output | 8 | Value of register `dbg_sel` (combinational) |
| pc_out | output | 12 | Program counter |
| done | output | 1 | One-cycle pulse, the cycle after an accepted word |

## Verification
All register writes and the program-counter step land on the edge that samples `instr_valid`. `done` rises on that same edge, so every result of an instruction is visible in the cycle in which `done` is high. The monitor waits for the falling edge at which it sees `done`, then compares the debug-port reads and `pc_out` against the scoreboard entry pushed by the driver. It finishes before the next rising edge can retire a further instruction. A `done` with no pending entry, and entries left over at the end, both count as failures, so a missing or misplaced pulse is caught.

// File: rtl/regop_pkg.sv
package regop_pkg;
  localparam int DW       = 8;
  localparam int NREG     = 16;
  localparam int IW       = $clog2(NREG);
  localparam int FLAG_IDX = NREG - 1;
  localparam logic [3:0] GROUP_NIB = 4'h8;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SUB,
    OP_SHR,
    OP_RSUB,
    OP_SHL
  } op_e;

  // {flag, difference}: flag set only for a strictly greater minuend
  function automatic logic [DW:0] f_sub(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW-1:0] d;
    d = a - b;
    return {(a > b), d};
  endfunction

  function automatic logic [DW:0] f_shr(input logic [DW-1:0] a);
    return {a[0], 1'b0, a[DW-1:1]};
  endfunction

  function automatic logic [DW:0] f_shl(input logic [DW-1:0] a);
    return {a[DW-1], a[DW-2:0], 1'b0};
  endfunction
endpackage

// File: rtl/regop_decode.sv
module regop_decode
  import regop_pkg::*;
(
  input  logic [15:0]   word,
  output op_e           op,
  output logic [IW-1:0] x_idx,
  output logic [IW-1:0] y_idx,
  output logic          legal
);
  always_comb begin
    x_idx = word[11:8];
    y_idx = word[7:4];
    op    = OP_NONE;
    if (word[15:12] == GROUP_NIB) begin
      case (word[3:0])
        4'h5:    op = OP_SUB;
        4'h6:    op = OP_SHR;
        4'h7:    op = OP_RSUB;
        4'hE:    op = OP_SHL;
        default: op = OP_NONE;
      endcase
    end
    legal = (op != OP_NONE);
  end
endmodule

// File: rtl/regop_alu.sv
module regop_alu
  import regop_pkg::*;
(
  input  op_e           op,
  input  logic [DW-1:0] vx,
  input  logic [DW-1:0] vy,
  output logic [DW-1:0] result,
  output logic          flag
);
  logic [DW:0] packed_out;

  always_comb begin
    case (op)
      OP_SUB:  packed_out = f_sub(vx, vy);
      OP_RSUB: packed_out = f_sub(vy, vx);
      OP_SHR:  packed_out = f_shr(vx);
      OP_SHL:  packed_out = f_shl(vx);
      default: packed_out = {1'b0, vx};
    endcase
    flag   = packed_out[DW];
    result = packed_out[DW-1:0];
  end
endmodule

// File: rtl/regop_regfile.sv
module regop_regfile
  import regop_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_we,
  input  logic [IW-1:0] res_idx,
  input  logic [DW-1:0] res_data,
  input  logic          flag_we,
  input  logic          flag_bit,
  input  logic          pre_we,
  input  logic [IW-1:0] pre_idx,
  input  logic [DW-1:0] pre_data,
  input  logic [IW-1:0] rd_a_idx,
  input  logic [IW-1:0] rd_b_idx,
  input  logic [IW-1:0] rd_c_idx,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  output logic [DW-1:0] rd_c,
  output logic [DW-1:0] flag_q
);
  logic [NREG-1:0][DW-1:0] regs_q;

  // result port has priority over the flag port (flag first, result second)
  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!rst_n)
        regs_q[i] <= '0;
      else if (res_we && res_idx == IW'(i))
        regs_q[i] <= res_data;
      else if (flag_we && i == FLAG_IDX)
        regs_q[i] <= {{(DW-1){1'b0}}, flag_bit};
      else if (pre_we && pre_idx == IW'(i))
        regs_q[i] <= pre_data;
    end
  end

  assign rd_a   = regs_q[rd_a_idx];
  assign rd_b   = regs_q[rd_b_idx];
  assign rd_c   = regs_q[rd_c_idx];
  assign flag_q = regs_q[FLAG_IDX];

  // R8: with no write strobe the whole file holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_we && !flag_we && !pre_we) |=> $stable(regs_q));

  // R6: result wins over flag on the flag register
  a_r6_result_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && flag_we && res_idx == IW'(FLAG_IDX)) |=> (flag_q == $past(res_data)));
endmodule

// File: rtl/regop_exec.sv
module regop_exec
  import regop_pkg::*;
#(
  parameter int          PC_W     = 12,
  parameter logic [11:0] PC_RESET = 12'h200,
  parameter int          PC_STEP  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [15:0]     instr_word,
  input  logic            pre_valid,
  input  logic [3:0]      pre_idx,
  input  logic [7:0]      pre_data,
  input  logic [3:0]      dbg_sel,
  output logic [7:0]      dbg_data,
  output logic [PC_W-1:0] pc_out,
  output logic            done
);
  op_e           op;
  logic [IW-1:0] x_idx, y_idx;
  logic          legal;
  logic [DW-1:0] vx, vy, result, vf_q;
  logic          flag;
  logic          exec_fire;
  logic          pre_fire;
  logic [PC_W-1:0] pc_q;
  logic            done_q;

  regop_decode u_dec (
    .word  (instr_word),
    .op    (op),
    .x_idx (x_idx),
    .y_idx (y_idx),
    .legal (legal)
  );

  regop_alu u_alu (
    .op     (op),
    .vx     (vx),
    .vy     (vy),
    .result (result),
    .flag   (flag)
  );

  assign exec_fire = instr_valid && legal;
  assign pre_fire  = pre_valid && !instr_valid;

  regop_regfile u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .res_we   (exec_fire),
    .res_idx  (x_idx),
    .res_data (result),
    .flag_we  (exec_fire),
    .flag_bit (flag),
    .pre_we   (pre_fire),
    .pre_idx  (pre_idx),
    .pre_data (pre_data),
    .rd_a_idx (x_idx),
    .rd_b_idx (y_idx),
    .rd_c_idx (dbg_sel),
    .rd_a     (vx),
    .rd_b     (vy),
    .rd_c     (dbg_data),
    .flag_q   (vf_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= PC_W'(PC_RESET);
      done_q <= 1'b0;
    end else begin
      done_q <= instr_valid;
      if (instr_valid) pc_q <= pc_q + PC_W'(PC_STEP);
    end
  end

  assign pc_out = pc_q;
  assign done   = done_q;

  // R9: one step per accepted word, modulo the counter width
  a_r9_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> (pc_q == PC_W'($past(pc_q) + PC_W'(PC_STEP))));

  a_r9_pc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable(pc_q));

  // R9: done follows the accepting cycle by exactly one
  a_r9_done_follow: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> done);

  a_r9_done_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> !done);

  // R2: strict compare drives the flag (x not the flag register)
  a_r2_sub_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && op == OP_SUB && x_idx != IW'(FLAG_IDX))
      |=> (vf_q == {{(DW-1){1'b0}}, ($past(vx) > $past(vy))}));

  // R4: shifted-out low bit lands in the flag register
  a_r4_shr_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && op == OP_SHR && x_idx != IW'(FLAG_IDX))
      |=> (vf_q == {{(DW-1){1'b0}}, $past(vx[0])}));
endmodule

// File: tb/regop_exec_bench.sv
module regop_exec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr_word = '0;
  logic        pre_valid = 1'b0;
  logic [3:0]  pre_idx = '0;
  logic [7:0]  pre_data = '0;
  logic [3:0]  dbg_sel = '0;
  logic [7:0]  dbg_data;
  logic [11:0] pc_out;
  logic        done;

  always #10 clk = ~clk;

  regop_exec u_regop_exec (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .pre_valid(pre_valid), .pre_idx(pre_idx), .pre_data(pre_data),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data), .pc_out(pc_out), .done(done)
  );

  typedef struct {
    logic [11:0]      pc;
    logic [3:0][3:0]  idx;
    logic [3:0][7:0]  val;
    string            req;
  } exp_t;

  exp_t q[$];
  int   mreg[16];
  int   mpc;
  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bench model: flag first, result second
  function automatic void model_exec(input logic [15:0] w);
    int x, y, a, b, r, f;
    bit hit;
    x = int'(w[11:8]); y = int'(w[7:4]);
    a = mreg[x]; b = mreg[y];
    hit = 1'b1; r = 0; f = 0;
    if (w[15:12] != 4'h8) hit = 1'b0;
    else if (w[3:0] == 4'h5) begin f = (a > b) ? 1 : 0; r = (a - b + 256) % 256; end
    else if (w[3:0] == 4'h7) begin f = (b > a) ? 1 : 0; r = (b - a + 256) % 256; end
    else if (w[3:0] == 4'h6) begin f = a % 2; r = a / 2; end
    else if (w[3:0] == 4'hE) begin f = a / 128; r = (a * 2) % 256; end
    else hit = 1'b0;
    if (hit) begin mreg[15] = f; mreg[x] = r; end
    mpc = (mpc + 2) % 4096;
  endfunction

  task automatic issue(input logic [15:0] w, input int extra, input string req,
                       input bit with_pre = 0, input int pidx = 0, input int pdat = 0);
    exp_t e;
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = w;
    pre_valid   = with_pre;
    pre_idx     = 4'(pidx);
    pre_data    = 8'(pdat);
    model_exec(w);
    e.pc  = 12'(mpc);
    e.idx[0] = w[11:8]; e.idx[1] = 4'hF; e.idx[2] = w[7:4]; e.idx[3] = 4'(extra);
    for (int k = 0; k < 4; k++) e.val[k] = 8'(mreg[e.idx[k]]);
    e.req = req;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    instr_valid = 1'b0;
    pre_valid   = 1'b0;
  endtask

  task automatic preload(input int idx, input int dat);
    @(negedge clk);
    instr_valid = 1'b0;
    pre_valid   = 1'b1;
    pre_idx     = 4'(idx);
    pre_data    = 8'(dat);
    mreg[idx]   = dat;
    @(negedge clk);
    pre_valid   = 1'b0;
  endtask

  // monitor: pops one entry per done pulse and compares within the low phase
  initial begin
    exp_t e;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (done) begin
        if (q.size() == 0) begin
          check("R9", "done without pending instruction", 1, 0);
        end else begin
          e = q.pop_front();
          #1;
          check(e.req, "pc", int'(pc_out), int'(e.pc));
          for (int k = 0; k < 4; k++) begin
            dbg_sel = e.idx[k];
            #1;
            check(e.req, $sformatf("V%0h", e.idx[k]), int'(dbg_data), int'(e.val[k]));
          end
        end
      end
    end
  end

  initial begin
    #3000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 16; i++) mreg[i] = 0;
    mpc = 12'h200;
    repeat (3) @(negedge clk);
    check("R1", "done during reset", int'(done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "pc after reset", int'(pc_out), 12'h200);
    check("R1", "done after reset", int'(done), 0);
    for (int i = 0; i < 16; i++) begin
      dbg_sel = 4'(i);
      #1;
      check("R1", $sformatf("V%0h after reset", i), int'(dbg_data), 0);
    end

    // R11 + R2: subtract with borrow, without borrow, equal operands
    preload(0, 8'h01); preload(1, 8'h02);
    issue(16'h8015, 1, "R2 borrow"); idle();
    preload(0, 8'h02); preload(1, 8'h01);
    issue(16'h8015, 1, "R2 no borrow"); idle();
    preload(2, 8'h05); preload(3, 8'h05);
    issue(16'h8235, 2, "R2 equal"); idle();

    // R3: reverse subtract
    preload(0, 8'h02); preload(1, 8'h01);
    issue(16'h8017, 1, "R3 borrow"); idle();
    preload(0, 8'h01); preload(1, 8'h02);
    issue(16'h8017, 1, "R3 no borrow"); idle();
    preload(8, 8'h9A); preload(9, 8'h9A);
    issue(16'h8897, 9, "R3 equal"); idle();

    // R4 + R10: shift right chain, Vy carries a value that must not matter
    preload(4, 8'h0F); preload(5, 8'h77);
    for (int i = 0; i < 5; i++) issue(16'h8456, 5, "R4 R10 shr");
    idle();

    // R5 + R10: shift left chain, back to back (R9)
    preload(6, 8'h0F); preload(5, 8'hC3);
    for (int i = 0; i < 5; i++) issue(16'h865E, 5, "R5 R10 shl");
    idle();

    // R6: destination is the flag register
    preload(15, 8'h10); preload(1, 8'h03);
    issue(16'h8F15, 1, "R6 sub into VF"); idle();
    preload(15, 8'h81);
    issue(16'h8F0E, 0, "R6 shl into VF"); idle();

    // R7: same register on both sides
    preload(7, 8'h40);
    issue(16'h8775, 7, "R7 sub self"); idle();
    preload(7, 8'h40);
    issue(16'h8777, 7, "R7 rsub self"); idle();

    // R8: unknown operation codes and foreign groups
    preload(10, 8'h5A); preload(11, 8'hA5); preload(15, 8'h33);
    issue(16'h8AB8, 10, "R8 bad low nibble");
    issue(16'h1AB5, 11, "R8 bad group");
    issue(16'hFAB6, 10, "R8 bad group shr"); idle();

    // R11: preload dropped while an instruction is accepted
    preload(12, 8'h11);
    issue(16'h8012, 12, "R11 dropped preload", 1'b1, 12, 8'hEE); idle();
    issue(16'h0000, 12, "R11 dropped preload"); idle();

    // R9: program counter wraps modulo 4096
    n = (4096 - mpc) / 2 + 2;
    for (int i = 0; i < n; i++) issue(16'h0000, 3, "R9 pc wrap");
    idle();

    repeat (4) @(negedge clk);
    check("R9", "pending entries", q.size(), 0);
    check("R9", "done idle", int'(done), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule